// File: doc/BRIEF.md
# Keypad Button Status Register

This block turns ten button lines into a 16-bit status word and holds a 16-bit control word for the key interrupt logic placed elsewhere on the chip. Each clock cycle it takes the current button lines, places them into status bit positions, clears any pair of opposing direction bits that are both pressed, and inverts the result. In the status word a pressed button reads 0 and a released button reads 1. The button lines must already be synchronous to `clk`.

A rotation input changes which of the four direction buttons feed the four direction status bits. This lets the device be held sideways. The opposing-pair rule is applied after the remapping, so it always acts on the status positions.

The control word holds ten per-key select flags, an enable bit and a condition bit. It is written through a simple register port that has byte enables. Both words can be read through a one-bit read address. They are also driven out continuously for the interrupt logic.

Top module: `keypad_status`

## Requirements
- R1: While `rst_n` is low, and right after reset is released, the status word is 16'hFFFF and the control word is 16'h0000.
- R2: The status word is active low and is registered: one cycle after the buttons are sampled, a pressed button reads 0 and a released button reads 1. Bits 15:10 always read 1.
- R3: With `rotate_i`=0, status bits 0..7 take buttons 5, 4, 8, 9, 3, 2, 0, 1, in that order.
- R4: With `rotate_i`=1, status bits 0..7 take buttons 5, 4, 8, 9, 0, 1, 2, 3, in that order.
- R5: If status bits 6 and 7 would both show pressed, both read 1 (released). This holds in either rotation mode.
- R6: If status bits 4 and 5 would both show pressed, both read 1 (released). This holds in either rotation mode.
- R7: Status bit 8 shows button 7 and status bit 9 shows button 6. Both are inverted, and neither is affected by rotation.
- R8: A write with `wr_addr_i`=1 updates each control byte whose `wr_be_i` bit is set (bit 0 is the low byte). Only bits 9:0, 14 (enable) and 15 (condition) are stored. Bits 13:10 read 0. Without such a write the control word holds its value.
- R9: A write with `wr_addr_i`=0 changes neither the status word nor the control word.
- R10: `rd_data_o` shows the status word when `rd_addr_i`=0 and the control word when `rd_addr_i`=1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_i | input | 10 | Button lines, 1 = pressed, indexed by button number |
| rotate_i | input | 1 | Rotation mode for the direction buttons |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write target: 0 status (ignored), 1 control |
| wr_be_i | input | 2 | Byte enables for the write |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 1 | Read select: 0 status, 1 control |
| rd_data_o | output | 16 | Selected register value |
| status_o | output | 16 | Active-low button status word |
| ctrl_o | output | 16 | Key interrupt control word |

## Verification
The status word is refreshed from the buttons in every cycle, so a register write and a button change can always fall in the same cycle. The bench provokes this in two ways. First, it writes the control word in the same cycle that it presses a button. Second, it writes to the status address while the buttons stay fixed. It then judges, one cycle later, that the control word holds only the masked write data and that the status word reflects only the buttons.

// File: rtl/keypad_status.sv
`timescale 1ns/1ps
module keypad_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [9:0]  btn_i,
  input  logic        rotate_i,
  input  logic        wr_en_i,
  input  logic        wr_addr_i,
  input  logic [1:0]  wr_be_i,
  input  logic [15:0] wr_data_i,
  input  logic        rd_addr_i,
  output logic [15:0] rd_data_o,
  output logic [15:0] status_o,
  output logic [15:0] ctrl_o
);
  localparam logic [15:0] CTRL_KEEP = 16'hC3FF;

  logic [7:0]  lo_map;
  logic        vert_both, horz_both;
  logic [15:0] pressed;
  logic [15:0] status_q, ctrl_q;
  logic        ctrl_wr;

  always_comb begin
    if (rotate_i)
      lo_map = {btn_i[3], btn_i[2], btn_i[1], btn_i[0], btn_i[9], btn_i[8], btn_i[4], btn_i[5]};
    else
      lo_map = {btn_i[1], btn_i[0], btn_i[2], btn_i[3], btn_i[9], btn_i[8], btn_i[4], btn_i[5]};
  end

  assign vert_both = &lo_map[7:6];
  assign horz_both = &lo_map[5:4];

  assign pressed = {6'b0, btn_i[6], btn_i[7],
                    vert_both ? 2'b00 : lo_map[7:6],
                    horz_both ? 2'b00 : lo_map[5:4],
                    lo_map[3:0]};

  assign ctrl_wr = wr_en_i && wr_addr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= 16'hFFFF;
      ctrl_q   <= 16'h0000;
    end else begin
      status_q <= ~pressed;
      if (ctrl_wr && wr_be_i[0]) ctrl_q[7:0]  <= wr_data_i[7:0]  & CTRL_KEEP[7:0];
      if (ctrl_wr && wr_be_i[1]) ctrl_q[15:8] <= wr_data_i[15:8] & CTRL_KEEP[15:8];
    end
  end

  assign status_o  = status_q;
  assign ctrl_o    = ctrl_q;
  assign rd_data_o = rd_addr_i ? ctrl_q : status_q;
endmodule

// File: rtl/keypad_status_chk.sv
`timescale 1ns/1ps
module keypad_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [9:0]  btn_i,
  input logic        wr_en_i,
  input logic        wr_addr_i,
  input logic        rd_addr_i,
  input logic [15:0] rd_data_o,
  input logic [15:0] status_o,
  input logic [15:0] ctrl_o
);
  // R2
  upper_bits_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[15:10] == 6'h3F);

  // R2
  idle_all_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_i == 10'd0) |=> (status_o == 16'hFFFF));

  // R5
  no_vertical_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7:6] != 2'b00);

  // R6
  no_horizontal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[5:4] != 2'b00);

  // R8
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[13:10] == 4'h0);

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_addr_i) |=> $stable(ctrl_o));

  // R10
  read_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_i |-> (rd_data_o == ctrl_o));
endmodule

bind keypad_status keypad_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .status_o(status_o), .ctrl_o(ctrl_o)
);

// File: tb/keypad_status_test.sv
`timescale 1ns/1ps
module keypad_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  btn_i = '0;
  logic        rotate_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_addr_i = 1'b0;
  logic [1:0]  wr_be_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        rd_addr_i = 1'b0;
  logic [15:0] rd_data_o, status_o, ctrl_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  keypad_status uut (.*);

  always #4 clk = ~clk;

  // {rotate, buttons[9:0], expected status}
  localparam int NV = 18;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 10'h000, 16'hFFFF},  // R2 idle
    {1'b0, 10'h001, 16'hFFBF},  // R3 button0 -> bit6
    {1'b0, 10'h020, 16'hFFFE},  // R3 button5 -> bit0
    {1'b0, 10'h100, 16'hFFFB},  // R3 button8 -> bit2
    {1'b0, 10'h080, 16'hFEFF},  // R7 button7 -> bit8
    {1'b0, 10'h040, 16'hFDFF},  // R7 button6 -> bit9
    {1'b0, 10'h003, 16'hFFFF},  // R5 vertical pair
    {1'b0, 10'h00C, 16'hFFFF},  // R6 horizontal pair
    {1'b0, 10'h005, 16'hFF9F},  // R3 mixed
    {1'b1, 10'h001, 16'hFFEF},  // R4 button0 -> bit4
    {1'b1, 10'h008, 16'hFF7F},  // R4 button3 -> bit7
    {1'b1, 10'h003, 16'hFFFF},  // R6 rotated horizontal pair
    {1'b1, 10'h00C, 16'hFFFF},  // R5 rotated vertical pair
    {1'b1, 10'h006, 16'hFF9F},  // R4 mixed
    {1'b1, 10'h330, 16'hFFF0},  // R4 fixed buttons
    {1'b0, 10'h3FF, 16'hFCF0},  // R5 R6 all pressed
    {1'b1, 10'h3FF, 16'hFCF0},  // R5 R6 all pressed rotated
    {1'b0, 10'h008, 16'hFFEF}   // R3 button3 -> bit4
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [1:0] be, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_be_i = be; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 status in reset", status_o, 16'hFFFF);
    check("R1 ctrl in reset", ctrl_o, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status after reset", status_o, 16'hFFFF);
    check("R1 ctrl after reset", ctrl_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      rotate_i = VEC[i][26];
      btn_i    = VEC[i][25:16];
      @(negedge clk);
      check($sformatf("R2/R3/R4 vector %0d", i), status_o, VEC[i][15:0]);
    end

    btn_i = '0; rotate_i = 1'b0;
    @(negedge clk);
    wr(1'b1, 2'b11, 16'hFFFF);
    check("R8 full write masked", ctrl_o, 16'hC3FF);
    wr(1'b1, 2'b01, 16'h0000);
    check("R8 low byte only", ctrl_o, 16'hC300);
    wr(1'b1, 2'b10, 16'h4155);
    check("R8 high byte only", ctrl_o, 16'h4100);
    wr(1'b0, 2'b11, 16'h0000);
    check("R9 status unchanged", status_o, 16'hFFFF);
    check("R9 ctrl unchanged", ctrl_o, 16'h4100);

    btn_i = 10'h020;
    wr(1'b1, 2'b11, 16'h8201);
    check("R8 ctrl with concurrent key", ctrl_o, 16'h8201);
    check("R2 key with concurrent write", status_o, 16'hFFFE);
    rd_addr_i = 1'b0; #1;
    check("R10 read status", rd_data_o, 16'hFFFE);
    rd_addr_i = 1'b1; #1;
    check("R10 read ctrl", rd_data_o, 16'h8201);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule